// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Parallel Result Port

This block is the digital control core of a successive-approximation converter. A falling edge on the active-low start strobe begins a conversion. The block holds `busy` high for a cycle count set by one of three modes: fast, normal or low-power. On the cycle that `busy` drops, it captures the 16-bit value on the result input into an output register. The analog front end, the capacitor DAC and the correction logic lie outside the block. They are represented by `adc_data` and by cycle-count parameters.

After each conversion a short acquisition window follows. In low-power mode, a start edge that arrives in that window launches the next conversion at once; the other modes ignore such an edge. An abort input cancels any conversion in progress and clears the block. A power-down input lets a running conversion finish and then refuses new ones. In fast mode, a monitor raises a flag when too long passes without a new start.

The stored result is presented on a 16-bit parallel bus. The bus can give straight binary or two's complement, the latter by inverting the top bit, and can exchange its two bytes. It is enabled only while chip-select and read are both low.

Top module: `adc_seq_core`

## Requirements
- R1: A start edge is a sampled high on `cnv_start_n` followed by a sampled low on the next clock. When the block is idle, not powered down and not aborting, this edge sets `busy` high from the following cycle.
- R2: `busy` stays high for exactly FAST_CYC, NORM_CYC or LOWP_CYC cycles, chosen by `mode_sel` at the start edge. The encodings are 2'b10 for fast, 2'b01 for low-power, and 2'b00 or 2'b11 for normal.
- R3: The result register takes `adc_data` on the same clock edge that lowers `busy`, so the new value is on `dout` in the first cycle with `busy` low.
- R4: A start edge that arrives while `busy` is high is ignored and does not change the length of the running conversion.
- R5: Each conversion is followed by ACQ_CYC acquisition cycles. During them, a start edge is ignored in fast and normal mode. In low-power mode, selected by the current `mode_sel`, it starts a conversion immediately.
- R6: `conv_abort` high at a clock edge cancels any conversion. After that edge `busy` is low, the result register reads zero and `gap_flag` is low.
- R7: While `pwr_down` is high, a running conversion completes with its full length and no new conversion starts.
- R8: With `fmt_straight` high, the output word equals the stored result. With it low, bit 15 is inverted.
- R9: With `swap_bytes` low, result bits 7:0 appear on `dout[7:0]` and bits 15:8 on `dout[15:8]`. With it high, the two bytes are exchanged. The exchange is applied after formatting.
- R10: `dout_en` is high exactly when `cs_n` and `rd_n` are both low. While it is low, `dout` is all zeros.
- R11: After a conversion starts in fast mode, `gap_flag` rises once more than GAP_LIMIT cycles pass without another accepted start. It stays high until the next accepted start, which clears it. A start in any other mode disarms the monitor.
- R12: After reset, `busy` is low, `gap_flag` is low and the result register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_abort | input | 1 | Active-high request that cancels a conversion and clears the block |
| pwr_down | input | 1 | Blocks new conversions while high |
| cnv_start_n | input | 1 | Active-low start strobe; the falling edge starts a conversion |
| mode_sel | input | 2 | Mode: bit 1 selects fast, bit 0 selects low-power |
| adc_data | input | 16 | Result from the comparator stub |
| fmt_straight | input | 1 | 1 = straight binary, 0 = top bit inverted |
| swap_bytes | input | 1 | Exchanges the two output bytes |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| busy | output | 1 | High while a conversion runs |
| gap_flag | output | 1 | Fast-mode start interval exceeded |
| dout | output | 16 | Parallel result bus, zero when disabled |
| dout_en | output | 1 | Bus drive enable |

## Verification
The bench goes after conversion length, measuring the `busy` width in each mode and with a start glitch inside the conversion. A design that restarted or stretched on that glitch would report a wrong width. It also probes the acquisition window in normal and in low-power mode. A block that ignored the mode there would either lose the early start in low-power or accept a premature one in normal. It checks that the new result is visible on the very cycle `busy` falls: a stage of output pipelining would show the old word there. It checks that an abort clears the stored word, and that the gap flag neither fires at exactly GAP_LIMIT cycles nor stays set after the next start, which is how an off-by-one counter or a sticky flag would show.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: mode select bit 1 = fast, bit 0 = low-power.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_FAST   = 2'd1,
        MODE_LOWPWR = 2'd2
    } conv_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_ACQ  = 2'd2
    } seq_state_t;

    // Map the two select pins onto a conversion mode; both-high or both-low is normal.
    function automatic conv_mode_t decode_mode(input logic [1:0] sel);
        case (sel)
            2'b10:   return MODE_FAST;
            2'b01:   return MODE_LOWPWR;
            default: return MODE_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
// Conversion sequencer: detects the start edge, runs the mode-dependent
// conversion count, then an acquisition window.
// Assumes: inputs are synchronous to clk; every cycle count is at least 1.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int FAST_CYC = 40,
    parameter int NORM_CYC = 50,
    parameter int LOWP_CYC = 60,
    parameter int ACQ_CYC  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       pwr_down,
    input  logic       cnv_start_n,
    input  logic [1:0] mode_sel,
    output logic       busy,
    output logic       start_acc,
    output logic       start_fast,
    output logic       done
);
    localparam int MAX_A  = (FAST_CYC > NORM_CYC) ? FAST_CYC : NORM_CYC;
    localparam int MAX_B  = (LOWP_CYC > ACQ_CYC) ? LOWP_CYC : ACQ_CYC;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAXLEN + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          prev_n;
    logic          start_fall;
    conv_mode_t    mode_now;

    // Count to load for a conversion in the given mode (length minus one).
    function automatic logic [CW-1:0] conv_len(input conv_mode_t m);
        case (m)
            MODE_FAST:   return CW'(FAST_CYC - 1);
            MODE_LOWPWR: return CW'(LOWP_CYC - 1);
            default:     return CW'(NORM_CYC - 1);
        endcase
    endfunction

    // Remember the previous strobe level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= 1'b1;
        else        prev_n <= cnv_start_n;
    end

    // Decode the edge and decide whether it may start a conversion now.
    always_comb begin
        start_fall = prev_n & ~cnv_start_n;
        mode_now   = decode_mode(mode_sel);
        start_acc  = start_fall && !abort && !pwr_down &&
                     ((state == ST_IDLE) ||
                      (state == ST_ACQ && mode_now == MODE_LOWPWR));
        start_fast = start_acc && (mode_now == MODE_FAST);
        done       = (state == ST_CONV) && (cnt == '0) && !abort;
    end

    // Sequencer state and shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_acc) begin
                        state <= ST_CONV;
                        cnt   <= conv_len(mode_now);
                    end
                end
                ST_CONV: begin
                    if (cnt == '0) begin
                        state <= ST_ACQ;
                        cnt   <= CW'(ACQ_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ACQ: begin
                    if (start_acc) begin
                        state <= ST_CONV;
                        cnt   <= conv_len(mode_now);
                    end else if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Busy flag straight from the state register.
    always_comb busy = (state == ST_CONV);

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_fall));

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |-> $past(done));

    // R6
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && state == ST_IDLE));

    // R7
    pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pwr_down) |=> !busy);

endmodule

// File: rtl/adc_gap_mon.sv
// Fast-mode start interval monitor: counts cycles since the last fast-mode
// start and flags when the count passes GAP_LIMIT.
// Assumes: start_fast implies start_acc.
module adc_gap_mon #(
    parameter int GAP_LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start_acc,
    input  logic start_fast,
    output logic gap_flag
);
    localparam int GW = $clog2(GAP_LIMIT + 2);
    localparam logic [GW-1:0] SAT = GW'(GAP_LIMIT + 1);

    logic [GW-1:0] gap;
    logic          armed;

    // Arm on a fast start, restart the count on every start, saturate past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            gap   <= '0;
            armed <= 1'b0;
        end else if (start_acc) begin
            gap   <= '0;
            armed <= start_fast;
        end else if (armed && gap != SAT) begin
            gap <= gap + 1'b1;
        end
    end

    // Flag once the interval is strictly longer than the limit.
    always_comb gap_flag = armed && (gap == SAT);

    // R11
    gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> !gap_flag);

    // R11
    gap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_flag) |-> ($past(gap) == GW'(GAP_LIMIT)));

endmodule

// File: rtl/adc_out_port.sv
// Result register and parallel output formatter: optional top-bit
// inversion, byte-lane reversal and a read enable.
// Assumes: W is a multiple of 8.
module adc_out_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         latch,
    input  logic [W-1:0] din,
    input  logic         fmt_straight,
    input  logic         swap_bytes,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    localparam int NB = W / 8;

    logic [W-1:0] res_q;
    logic [W-1:0] fmt_w;
    logic [W-1:0] rev_w;

    // Capture the conversion result on the final conversion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) res_q <= '0;
        else if (latch)      res_q <= din;
    end

    // Apply the number format by flipping the top bit when requested.
    always_comb fmt_w = {res_q[W-1] ^ ~fmt_straight, res_q[W-2:0]};

    // Reverse the byte lanes.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign rev_w[i*8 +: 8] = fmt_w[(NB-1-i)*8 +: 8];
    end

    // Drive the bus only during a read.
    always_comb begin
        dout_en = ~cs_n & ~rd_n;
        dout    = dout_en ? (swap_bytes ? rev_w : fmt_w) : '0;
    end

    // R3
    latch_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (res_q == $past(din)));

    // R10
    bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

endmodule

// File: rtl/adc_seq_core.sv
// Top of the conversion sequencer: ties the sequencer, the fast-mode
// interval monitor and the parallel output port together.
// Assumes: all inputs are synchronous to clk.
module adc_seq_core #(
    parameter int W         = 16,
    parameter int FAST_CYC  = 40,
    parameter int NORM_CYC  = 50,
    parameter int LOWP_CYC  = 60,
    parameter int ACQ_CYC   = 12,
    parameter int GAP_LIMIT = 50000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_abort,
    input  logic         pwr_down,
    input  logic         cnv_start_n,
    input  logic [1:0]   mode_sel,
    input  logic [W-1:0] adc_data,
    input  logic         fmt_straight,
    input  logic         swap_bytes,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic         busy,
    output logic         gap_flag,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    logic start_acc;
    logic start_fast;
    logic done;

    adc_seq_ctrl #(
        .FAST_CYC (FAST_CYC),
        .NORM_CYC (NORM_CYC),
        .LOWP_CYC (LOWP_CYC),
        .ACQ_CYC  (ACQ_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (conv_abort),
        .pwr_down    (pwr_down),
        .cnv_start_n (cnv_start_n),
        .mode_sel    (mode_sel),
        .busy        (busy),
        .start_acc   (start_acc),
        .start_fast  (start_fast),
        .done        (done)
    );

    adc_gap_mon #(
        .GAP_LIMIT (GAP_LIMIT)
    ) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (conv_abort),
        .start_acc  (start_acc),
        .start_fast (start_fast),
        .gap_flag   (gap_flag)
    );

    adc_out_port #(
        .W (W)
    ) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort        (conv_abort),
        .latch        (done),
        .din          (adc_data),
        .fmt_straight (fmt_straight),
        .swap_bytes   (swap_bytes),
        .cs_n         (cs_n),
        .rd_n         (rd_n),
        .dout         (dout),
        .dout_en      (dout_en)
    );

endmodule

// File: tb/adc_seq_core_test.sv
module adc_seq_core_test;
    localparam int FAST = 12;
    localparam int NORM = 16;
    localparam int LOWP = 20;
    localparam int ACQ  = 5;
    localparam int GAP  = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_abort = 1'b0;
    logic        pwr_down = 1'b0;
    logic        cnv_start_n = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic [15:0] adc_data = 16'h0000;
    logic        fmt_straight = 1'b1;
    logic        swap_bytes = 1'b0;
    logic        cs_n = 1'b0;
    logic        rd_n = 1'b0;
    logic        busy, gap_flag, dout_en;
    logic [15:0] dout;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_seq_core #(
        .FAST_CYC(FAST), .NORM_CYC(NORM), .LOWP_CYC(LOWP),
        .ACQ_CYC(ACQ), .GAP_LIMIT(GAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .conv_abort(conv_abort), .pwr_down(pwr_down),
        .cnv_start_n(cnv_start_n), .mode_sel(mode_sel), .adc_data(adc_data),
        .fmt_straight(fmt_straight), .swap_bytes(swap_bytes), .cs_n(cs_n),
        .rd_n(rd_n), .busy(busy), .gap_flag(gap_flag), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_busy = 0, m_remain = 0, m_acq = 0, m_gap = 0, m_armed = 0;
    int m_prev = 1;
    logic [15:0] m_result = 16'h0;

    function automatic int mode_len(input logic [1:0] s);
        if (s == 2'b10) return FAST;
        if (s == 2'b01) return LOWP;
        return NORM;
    endfunction

    always @(posedge clk) begin
        bit fall, take;
        fall = (m_prev == 1) && (cnv_start_n == 1'b0);
        take = 1'b0;
        if (!rst_n || conv_abort) begin
            m_busy = 0; m_remain = 0; m_acq = 0; m_gap = 0; m_armed = 0;
            m_result = 16'h0;
        end else begin
            if (m_busy != 0) begin
                m_remain--;
                if (m_remain == 0) begin
                    m_busy = 0; m_result = adc_data; m_acq = ACQ;
                end
            end else if (m_acq > 0) begin
                if (fall && !pwr_down && mode_sel == 2'b01) take = 1'b1;
                else m_acq--;
            end else begin
                if (fall && !pwr_down) take = 1'b1;
            end
            if (take) begin
                m_busy = 1; m_acq = 0; m_remain = mode_len(mode_sel);
                m_gap = 0; m_armed = (mode_sel == 2'b10);
            end else if (m_armed != 0 && m_gap <= GAP) begin
                m_gap++;
            end
        end
        m_prev = rst_n ? int'(cnv_start_n) : 1;
    end

    // Compare every cycle, well after the drivers settle.
    always @(negedge clk) begin
        logic [15:0] w;
        #5;
        if (cmp_on && !finished) begin
            w = fmt_straight ? m_result : {~m_result[15], m_result[14:0]};
            if (swap_bytes) w = {w[7:0], w[15:8]};
            if (cs_n || rd_n) w = 16'h0;
            check("R2 model busy", busy, m_busy != 0);
            check("R3 model dout", dout, w);
            check("R10 model en", dout_en, !cs_n && !rd_n);
            check("R11 model flag", gap_flag, (m_armed != 0) && (m_gap > GAP));
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic do_conv(input logic [1:0] msel, input logic [15:0] d,
                           input bit glitch, output int width);
        mode_sel = msel; adc_data = d; cnv_start_n = 1'b0;
        @(negedge clk);
        cnv_start_n = 1'b1;
        width = 0;
        while (busy) begin
            width++;
            if (glitch && width == 3) cnv_start_n = 1'b0;
            if (glitch && width == 5) cnv_start_n = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (ACQ + 3) @(negedge clk);
    endtask

    initial begin
        int wd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        #1;
        // R12 reset state
        check("R12 busy", busy, 0);
        check("R12 flag", gap_flag, 0);
        check("R12 dout", dout, 16'h0000);
        @(negedge clk);

        // R1 R2 R3 normal conversion
        do_conv(2'b00, 16'h1234, 0, wd);
        check("R1 R2 normal width", wd, NORM);
        check("R3 dout at busy fall", dout, 16'h1234);
        settle();
        do_conv(2'b10, 16'hA5C3, 0, wd);
        check("R2 fast width", wd, FAST);
        settle();
        do_conv(2'b01, 16'h0F0F, 0, wd);
        check("R2 lowpwr width", wd, LOWP);
        settle();
        do_conv(2'b11, 16'h7777, 0, wd);
        check("R2 both-high is normal", wd, NORM);
        settle();

        // R4 glitch inside conversion
        do_conv(2'b00, 16'h1234, 1, wd);
        check("R4 glitch width", wd, NORM);
        check("R4 result", dout, 16'h1234);

        // R5 acquisition window, normal: ignored
        cnv_start_n = 1'b0;
        @(negedge clk);
        check("R5 normal acq start ignored", busy, 0);
        cnv_start_n = 1'b1;
        settle();

        // R5 acquisition window, low-power: accepted
        do_conv(2'b01, 16'h2222, 0, wd);
        cnv_start_n = 1'b0;
        @(negedge clk);
        check("R5 lowpwr acq start taken", busy, 1);
        cnv_start_n = 1'b1;
        while (busy) @(negedge clk);
        settle();

        // R8 R9 R10 formatting on stored 0x1234
        do_conv(2'b00, 16'h1234, 0, wd);
        fmt_straight = 1'b0; #1;
        check("R8 top bit inverted", dout, 16'h9234);
        swap_bytes = 1'b1; #1;
        check("R9 swap after format", dout, 16'h3492);
        fmt_straight = 1'b1; #1;
        check("R9 swap straight", dout, 16'h3412);
        cs_n = 1'b1; #1;
        check("R10 en low", dout_en, 0);
        check("R10 bus zero", dout, 16'h0000);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R10 rd high", dout_en, 0);
        rd_n = 1'b0; swap_bytes = 1'b0; #1;
        check("R10 en high", dout_en, 1);
        settle();

        // R7 power-down during a conversion
        mode_sel = 2'b00; adc_data = 16'h4444; cnv_start_n = 1'b0;
        @(negedge clk);
        cnv_start_n = 1'b1; pwr_down = 1'b1; wd = 0;
        while (busy) begin wd++; @(negedge clk); end
        check("R7 full length", wd, NORM);
        check("R7 result", dout, 16'h4444);
        settle();
        cnv_start_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 start blocked", busy, 0);
        cnv_start_n = 1'b1; pwr_down = 1'b0;
        @(negedge clk);

        // R6 abort mid-conversion
        mode_sel = 2'b00; adc_data = 16'hBEEF; cnv_start_n = 1'b0;
        @(negedge clk);
        cnv_start_n = 1'b1;
        repeat (3) @(negedge clk);
        conv_abort = 1'b1;
        @(negedge clk);
        conv_abort = 1'b0;
        check("R6 busy cleared", busy, 0);
        check("R6 result cleared", dout, 16'h0000);
        settle();

        // R11 fast-mode gap flag
        do_conv(2'b10, 16'h0101, 0, wd);
        repeat (GAP - FAST - 2) @(negedge clk);
        check("R11 flag not yet", gap_flag, 0);
        repeat (10) @(negedge clk);
        check("R11 flag raised", gap_flag, 1);
        do_conv(2'b00, 16'h0202, 0, wd);
        check("R11 cleared by start", gap_flag, 0);
        settle();
        do_conv(2'b10, 16'h0303, 0, wd);
        conv_abort = 1'b1;
        @(negedge clk);
        conv_abort = 1'b0;
        repeat (GAP + 5) @(negedge clk);
        check("R6 abort disarms R11", gap_flag, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule